// File: doc/BRIEF.md
# Fixed-Gain Two-Axis Position Tracker

This block estimates the position of a moving target in two dimensions. It assumes the target moves at constant velocity and uses a Kalman filter whose gains are worked out offline and loaded at run time. It keeps a position and a velocity for each axis. Each noisy position measurement it takes in moves that estimate toward the observation, and each filtered position it produces goes out through a queue.

A producer writes measurement words into an internal input queue, and a consumer reads filtered words from an internal output queue. Both queues are built so that they can map onto block RAM. The two gains, the time step, and the initial position and velocity all arrive on a configuration port and take effect on a single load strobe. The block processes one sample at a time on a fixed three-phase schedule. Before it takes a sample, it checks that the output queue has room, so a slow consumer stalls the whole filter and no result is ever dropped.

Top module: `kalman_track2d`

## Requirements
- R1: After synchronous reset, `in_full` is low and `out_empty` is high. The gains, time step, positions and velocities are all zero.
- R2: Every queue word holds X in bits 31:16 and Y in bits 15:0. Each coordinate is a 16-bit two's complement number with 7 fraction bits. With both gains and the step loaded as zero, each output word equals the loaded initial position.
- R3: On each axis, one sample z produces p = x + mul(v, T), e = z - p, new x = p + mul(Kp, e) and new v = v + mul(Kv, e). The new x is the output coordinate. mul(a, b) is the full product plus 64, shifted arithmetically right by 7.
- R4: Every sum, difference and mul result is clamped to the range -32768 to 32767 before it is used further.
- R5: The updated state of one sample is the starting state of the next. Results leave in the order their measurements arrived.
- R6: While the output queue is full, the block takes no measurement from the input queue. Measurements that are waiting are kept and processed once room appears, and no result is lost.
- R7: Two samples are taken from the input queue at least 3 cycles apart. Assume the block is idle with empty queues. A measurement written at clock edge n sets `out_empty` low after edge n+3. A second measurement written at edge n+1 appears after edge n+6.
- R8: `cfg_load` loads both gains, the step, the initial positions and the initial velocities at the next edge. The next result is computed from the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr_en | input | 1 | Write a measurement word; ignored while full |
| in_wr_data | input | 32 | Measurement, X in 31:16 and Y in 15:0 |
| in_full | output | 1 | Input queue full |
| out_rd_en | input | 1 | Read a result word; ignored while empty |
| out_rd_data | output | 32 | Result word, valid the cycle after a read |
| out_empty | output | 1 | Output queue empty |
| cfg_load | input | 1 | Load configuration strobe |
| cfg_gain_pos | input | 16 | Position gain Kp, Q8.7 |
| cfg_gain_vel | input | 16 | Velocity gain Kv, Q8.7 |
| cfg_step | input | 16 | Time step T, Q8.7 |
| cfg_pos0 | input | 32 | Initial position, X in 31:16 and Y in 15:0 |
| cfg_vel0 | input | 32 | Initial velocity, X in 31:16 and Y in 15:0 |

## Verification
Four properties are checked on every cycle. Samples are spaced by three phases, every sample taken is followed by an update two cycles later, no result is pushed into a full output queue, and the input queue never shrinks while the output is full. A fifth cycle check confirms that a load places the configured position into the state. The numeric content of the results can only be shown by the bench scenarios, which compare every word against a behavioural model. This covers the rounding, the clamping at both extremes, the carrying of state from one sample to the next, the exact latency, and the recovery of waiting samples after a stall.

// File: rtl/kt_pkg.sv
package kt_pkg;
  localparam int CW = 16;
  localparam int FW = 7;
  localparam int WW = 2 * CW + 2;

  typedef logic signed [CW-1:0] coord_t;
  typedef logic signed [WW-1:0] wide_t;
  typedef enum logic [1:0] {PH_IDLE, PH_PRED, PH_UPD} phase_t;

  function automatic wide_t widen(input coord_t a);
    return {{(WW-CW){a[CW-1]}}, a};
  endfunction

  function automatic coord_t clamp(input wide_t v);
    wide_t hi;
    wide_t lo;
    hi = widen({1'b0, {(CW-1){1'b1}}});
    lo = widen({1'b1, {(CW-1){1'b0}}});
    if (v > hi) return {1'b0, {(CW-1){1'b1}}};
    else if (v < lo) return {1'b1, {(CW-1){1'b0}}};
    else return v[CW-1:0];
  endfunction

  function automatic coord_t add_sat(input coord_t a, input coord_t b);
    return clamp(widen(a) + widen(b));
  endfunction

  function automatic coord_t sub_sat(input coord_t a, input coord_t b);
    return clamp(widen(a) - widen(b));
  endfunction

  function automatic coord_t mul_rnd(input coord_t a, input coord_t b);
    wide_t prod;
    prod = widen(a) * widen(b);
    prod = prod + (wide_t'(1) <<< (FW - 1));
    return clamp(prod >>> FW);
  endfunction
endpackage

// File: rtl/kt_fifo.sv
module kt_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  output logic                       full,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           rd_data,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             wr_ok, rd_ok;

  assign full  = (count == NW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/kt_ctrl.sv
module kt_ctrl
  import kt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_empty,
  input  logic out_full,
  output logic pop,
  output logic pred,
  output logic upd
);
  phase_t ph;

  assign pop  = (ph == PH_IDLE) && !in_empty && !out_full;
  assign pred = (ph == PH_PRED);
  assign upd  = (ph == PH_UPD);

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else begin
      case (ph)
        PH_IDLE: if (pop) ph <= PH_PRED;
        PH_PRED: ph <= PH_UPD;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R7: a taken sample blocks the next two cycles
  p_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    pop |=> (!pop ##1 !pop));

  // R3: every taken sample is followed by its update
  p_update_follows_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> ##2 upd);
endmodule

// File: rtl/kt_axis.sv
module kt_axis
  import kt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  coord_t pos0,
  input  coord_t vel0,
  input  coord_t k_pos,
  input  coord_t k_vel,
  input  coord_t step,
  input  coord_t z,
  input  logic   pred,
  input  logic   upd,
  output coord_t pos_next
);
  coord_t pos_q, vel_q, prd_q;
  coord_t err, vel_next;

  always_comb begin
    err      = sub_sat(z, prd_q);
    pos_next = add_sat(prd_q, mul_rnd(k_pos, err));
    vel_next = add_sat(vel_q, mul_rnd(k_vel, err));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      vel_q <= '0;
      prd_q <= '0;
    end else begin
      if (pred) prd_q <= add_sat(pos_q, mul_rnd(vel_q, step));
      if (load) begin
        pos_q <= pos0;
        vel_q <= vel0;
      end else if (upd) begin
        pos_q <= pos_next;
        vel_q <= vel_next;
      end
    end
  end

  // R8: a load places the configured position into the state
  p_load_pos_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (pos_q == $past(pos0)));
endmodule

// File: rtl/kalman_track2d.sv
module kalman_track2d
  import kt_pkg::*;
#(
  parameter int IN_DEPTH  = 512,
  parameter int OUT_DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_wr_en,
  input  logic [2*CW-1:0]   in_wr_data,
  output logic              in_full,
  input  logic              out_rd_en,
  output logic [2*CW-1:0]   out_rd_data,
  output logic              out_empty,
  input  logic              cfg_load,
  input  logic [CW-1:0]     cfg_gain_pos,
  input  logic [CW-1:0]     cfg_gain_vel,
  input  logic [CW-1:0]     cfg_step,
  input  logic [2*CW-1:0]   cfg_pos0,
  input  logic [2*CW-1:0]   cfg_vel0
);
  localparam int WORD_W = 2 * CW;
  localparam int ICW    = $clog2(IN_DEPTH + 1);
  localparam int OCW    = $clog2(OUT_DEPTH + 1);
  localparam int AXES   = 2;

  logic [WORD_W-1:0] meas;
  logic [ICW-1:0]    in_cnt;
  logic [OCW-1:0]    out_cnt;
  logic              in_empty, out_full;
  logic              pop, pred, upd;
  coord_t            kp_q, kv_q, step_q;
  coord_t            nxt [AXES];

  always_ff @(posedge clk) begin
    if (rst) begin
      kp_q   <= '0;
      kv_q   <= '0;
      step_q <= '0;
    end else if (cfg_load) begin
      kp_q   <= cfg_gain_pos;
      kv_q   <= cfg_gain_vel;
      step_q <= cfg_step;
    end
  end

  kt_fifo #(.WIDTH(WORD_W), .DEPTH(IN_DEPTH)) u_in_q (
    .clk(clk), .rst(rst),
    .wr_en(in_wr_en), .wr_data(in_wr_data), .full(in_full),
    .rd_en(pop), .rd_data(meas), .empty(in_empty), .count(in_cnt)
  );

  kt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_empty(in_empty), .out_full(out_full),
    .pop(pop), .pred(pred), .upd(upd)
  );

  // axis 0 is X in the upper half, axis 1 is Y in the lower half
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    localparam int LO = (AXES - 1 - a) * CW;
    kt_axis u_axis (
      .clk(clk), .rst(rst), .load(cfg_load),
      .pos0(cfg_pos0[LO +: CW]), .vel0(cfg_vel0[LO +: CW]),
      .k_pos(kp_q), .k_vel(kv_q), .step(step_q),
      .z(meas[LO +: CW]), .pred(pred), .upd(upd),
      .pos_next(nxt[a])
    );
  end

  kt_fifo #(.WIDTH(WORD_W), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk(clk), .rst(rst),
    .wr_en(upd), .wr_data({nxt[0], nxt[1]}), .full(out_full),
    .rd_en(out_rd_en), .rd_data(out_rd_data), .empty(out_empty),
    .count(out_cnt)
  );

  // R6: a result is never pushed into a full output queue
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    upd |-> (out_cnt < OCW'(OUT_DEPTH)));

  // R6: waiting measurements are not consumed while the output is full
  p_hold_input_r6: assert property (@(posedge clk) disable iff (rst)
    out_full |=> (in_cnt >= $past(in_cnt)));
endmodule

// File: tb/kalman_track2d_bench.sv
`timescale 1ns/1ps
module kalman_track2d_bench;
  localparam int ODEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_wr_en = 1'b0;
  logic [31:0] in_wr_data = '0;
  logic        in_full;
  logic        out_rd_en = 1'b0;
  logic [31:0] out_rd_data;
  logic        out_empty;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_gain_pos = '0, cfg_gain_vel = '0, cfg_step = '0;
  logic [31:0] cfg_pos0 = '0, cfg_vel0 = '0;

  int checks = 0;
  int fails  = 0;
  int mkp = 0, mkv = 0, mt = 0;
  int mx = 0, my = 0, mvx = 0, mvy = 0;
  logic [31:0] expq [$];

  always #2 clk = ~clk;

  kalman_track2d #(.IN_DEPTH(512), .OUT_DEPTH(ODEPTH)) u_kalman_track2d (
    .clk(clk), .rst(rst), .in_wr_en(in_wr_en), .in_wr_data(in_wr_data),
    .in_full(in_full), .out_rd_en(out_rd_en), .out_rd_data(out_rd_data),
    .out_empty(out_empty), .cfg_load(cfg_load), .cfg_gain_pos(cfg_gain_pos),
    .cfg_gain_vel(cfg_gain_vel), .cfg_step(cfg_step), .cfg_pos0(cfg_pos0),
    .cfg_vel0(cfg_vel0)
  );

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int mr(int a, int b);
    longint p;
    p = longint'(a) * longint'(b);
    p = (p + 64) >>> 7;
    return sat16(p);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic axis_step(input int z, inout int x, inout int v);
    int p, e;
    p = sat16(longint'(x) + mr(v, mt));
    e = sat16(longint'(z) - p);
    x = sat16(longint'(p) + mr(mkp, e));
    v = sat16(longint'(v) + mr(mkv, e));
  endtask

  task automatic load(int kp, int kv, int t, int x0, int y0, int vx0, int vy0);
    cfg_gain_pos = 16'(kp); cfg_gain_vel = 16'(kv); cfg_step = 16'(t);
    cfg_pos0 = {16'(x0), 16'(y0)};
    cfg_vel0 = {16'(vx0), 16'(vy0)};
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    mkp = kp; mkv = kv; mt = t;
    mx = x0; my = y0; mvx = vx0; mvy = vy0;
  endtask

  task automatic push(int zx, int zy);
    in_wr_data = {16'(zx), 16'(zy)};
    in_wr_en = 1'b1;
    tick();
    in_wr_en = 1'b0;
    axis_step(zx, mx, mvx);
    axis_step(zy, my, mvy);
    expq.push_back({16'(mx), 16'(my)});
  endtask

  task automatic pull(string req);
    logic [31:0] e;
    for (int n = 0; n < 200 && out_empty; n++) tick();
    out_rd_en = 1'b1;
    tick();
    out_rd_en = 1'b0;
    e = (expq.size() > 0) ? expq.pop_front() : 32'hxxxx_xxxx;
    chk(out_rd_data === e, req, "result word", out_rd_data, e);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] e;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    chk(in_full == 1'b0, "R1", "in_full after reset", 32'(in_full), 32'd0);
    chk(out_empty == 1'b1, "R1", "out_empty after reset", 32'(out_empty), 32'd1);

    // R2: zero gains and step pass the initial position through
    load(0, 0, 0, 300, -450, 77, -5);
    push(1000, 2000);
    for (int n = 0; n < 20 && out_empty; n++) tick();
    out_rd_en = 1'b1; tick(); out_rd_en = 1'b0;
    e = expq.pop_front();
    chk(out_rd_data[31:16] == 16'(300), "R2", "X field", 32'(out_rd_data[31:16]), 32'(16'(300)));
    chk(out_rd_data[15:0] == 16'(-450), "R2", "Y field", 32'(out_rd_data[15:0]), 32'(16'(-450)));
    chk(out_rd_data === e, "R2", "model word", out_rd_data, e);

    // R7 and R3: exact timing of two back-to-back samples
    load(64, 32, 128, 128, -256, 64, 0);
    push(200, -300);
    push(260, -310);
    chk(out_empty == 1'b1, "R7", "empty after n+1", 32'(out_empty), 32'd1);
    tick();
    chk(out_empty == 1'b1, "R7", "empty after n+2", 32'(out_empty), 32'd1);
    tick();
    chk(out_empty == 1'b0, "R7", "result after n+3", 32'(out_empty), 32'd0);
    out_rd_en = 1'b1; tick(); out_rd_en = 1'b0;
    e = expq.pop_front();
    chk(out_rd_data === e, "R3", "first result", out_rd_data, e);
    chk(out_empty == 1'b1, "R7", "empty after n+4", 32'(out_empty), 32'd1);
    tick();
    chk(out_empty == 1'b1, "R7", "empty after n+5", 32'(out_empty), 32'd1);
    tick();
    chk(out_empty == 1'b0, "R7", "second result after n+6", 32'(out_empty), 32'd0);
    pull("R3");

    // R5: a track carries state across samples
    load(90, 20, 64, -1000, 500, 40, -30);
    for (int i = 0; i < 6; i++) begin
      push(-1000 + 35 * i + ((i % 2) ? 9 : -7), 500 - 22 * i);
      pull("R5");
    end
    push(-700, 380);
    push(-690, 360);
    pull("R5");
    pull("R5");

    // R4: clamping at both ends
    load(128, 128, 128, 32000, -32000, 32000, -32000);
    push(-32768, 32767);
    pull("R4");
    push(32767, -32768);
    pull("R4");

    // R6: full output queue stalls the filter with nothing lost
    load(50, 10, 128, 0, 0, 100, -100);
    for (int i = 0; i < ODEPTH + 2; i++) push(120 * i, -90 * i);
    repeat (40) tick();
    chk(out_empty == 1'b0, "R6", "results waiting", 32'(out_empty), 32'd0);
    for (int i = 0; i < ODEPTH + 2; i++) pull("R6");
    repeat (10) tick();
    chk(out_empty == 1'b1, "R6", "no extra result", 32'(out_empty), 32'd1);

    // R8: reload replaces gains and state
    load(32, 64, 256, 4000, -4000, -10, 10);
    push(4100, -3900);
    pull("R8");
    push(4050, -3950);
    pull("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule